// File: doc/BRIEF.md
# Event interrupt status and mask unit

This block keeps the interrupt state for two event sources: a delay event and an overflow event. Each source has a raw pending bit, an interrupt enable bit and a wake-up enable bit. One-cycle event pulses set the raw bits. A simple word-addressed bus reads and writes the state through several register views. Two of these views are the separate enable-set and enable-clear registers. Two more are older status and enable registers that alias the same storage.

The block drives a level-sensitive interrupt output. It is high while any event is both pending and enabled. It also drives a wake-up request output, which is high while any event is pending and has its wake-up enable set. Software can force a raw bit high for debug. Software clears a pending event by writing 1 to the masked view or to the older status view. Either write clears the raw bit, whether or not the event is enabled.

Top module: `irq_event_unit`

## Requirements
- R1: After the asynchronous reset, every raw, enable and wake-up enable bit is 0, `irq_o` and `wake_o` are 0, and every register reads 0.
- R2: A 1 on `ev_i[k]` sets raw bit k on that clock edge, whether or not event k is enabled. Bit 1 is the delay event and bit 0 is the overflow event, in every register view.
- R3: A write to address 0 (raw view) sets each raw bit whose data bit is 1 and leaves every other raw bit unchanged. Address 0 reads back the raw vector.
- R4: Address 1 (masked view) reads, for each event, raw AND enable.
- R5: A write to address 1 clears each raw bit whose data bit is 1, even when that event is disabled. Data bits that are 0 have no effect.
- R6: A write to address 2 sets the enable bits whose data bit is 1. A write to address 3 clears them. Addresses 2 and 3 both read the enable vector.
- R7: Address 4 is an alias of the raw vector that reads raw and clears on a write of 1. Address 5 is an alias of the enable vector that reads it and loads it directly. A write through an alias is visible through the other views.
- R8: Address 6 holds the wake-up enable vector and can be read and written. `wake_o` is the OR over events of raw AND wake-up enable.
- R9: `irq_o` is the OR over events of raw AND enable, and it stays high for as long as that holds.
- R10: When an event pulse and a clearing write to the same raw bit fall in the same cycle, the bit ends set.
- R11: Data bits above bit 1 are ignored on write and read as 0. Addresses 7 to 15 read 0 and ignore writes. `rdata_o` is 0 unless a read (`req_i`=1, `we_i`=0) is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 2 | One-cycle event pulses, bit 1 delay, bit 0 overflow |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Level interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Two functions can fall in the same cycle: an event pulse arriving on `ev_i`, and a bus write that clears or sets the same raw bit through the masked view or the older status view. The bench drives the pulse and the clearing write on the same clock edge, for one bit and then for both bits. It then reads the raw view and expects the pulsed bits to stay set and an unpulsed bit to clear. A behavioural model steps on every clock and also judges `irq_o` and `wake_o` in each of those cycles.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    REG_RAW      = 4'd0,
    REG_MASKED   = 4'd1,
    REG_EN_SET   = 4'd2,
    REG_EN_CLR   = 4'd3,
    REG_LEG_STAT = 4'd4,
    REG_LEG_EN   = 4'd5,
    REG_WAKE_EN  = 4'd6
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EV = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_EV-1:0] raw_set_o,
  output logic [NUM_EV-1:0] raw_clr_o,
  output logic [NUM_EV-1:0] en_set_o,
  output logic [NUM_EV-1:0] en_clr_o,
  output logic              en_load_o,
  output logic              wake_load_o,
  output logic [NUM_EV-1:0] bits_o
);
  logic     wr;
  reg_sel_e sel;
  logic     unused_wdata;

  assign wr           = req_i & we_i;
  assign sel          = reg_sel_e'(addr_i);
  assign bits_o       = wdata_i[NUM_EV-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_EV];

  always_comb begin
    raw_set_o   = '0;
    raw_clr_o   = '0;
    en_set_o    = '0;
    en_clr_o    = '0;
    en_load_o   = 1'b0;
    wake_load_o = 1'b0;
    if (wr) begin
      case (sel)
        REG_RAW:                  raw_set_o   = bits_o;
        REG_MASKED, REG_LEG_STAT: raw_clr_o   = bits_o;
        REG_EN_SET:               en_set_o    = bits_o;
        REG_EN_CLR:               en_clr_o    = bits_o;
        REG_LEG_EN:               en_load_o   = 1'b1;
        REG_WAKE_EN:              wake_load_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_event_slice.sv
module irq_event_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic raw_set_i,
  input  logic raw_clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic en_load_i,
  input  logic wake_load_i,
  input  logic bit_i,
  output logic raw_o,
  output logic en_o,
  output logic wake_en_o,
  output logic masked_o,
  output logic wake_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o     <= 1'b0;
      en_o      <= 1'b0;
      wake_en_o <= 1'b0;
    end else begin
      // set sources dominate the clear
      raw_o <= ev_i | raw_set_i | (raw_o & ~raw_clr_i);
      if (en_load_i) en_o <= bit_i;
      else           en_o <= en_set_i | (en_o & ~en_clr_i);
      if (wake_load_i) wake_en_o <= bit_i;
    end
  end

  assign masked_o   = raw_o & en_o;
  assign wake_req_o = raw_o & wake_en_o;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EV = 2
) (
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [NUM_EV-1:0] raw_i,
  input  logic [NUM_EV-1:0] en_i,
  input  logic [NUM_EV-1:0] wake_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_EV-1:0] val;

  always_comb begin
    case (reg_sel_e'(addr_i))
      REG_RAW, REG_LEG_STAT:            val = raw_i;
      REG_MASKED:                       val = raw_i & en_i;
      REG_EN_SET, REG_EN_CLR, REG_LEG_EN: val = en_i;
      REG_WAKE_EN:                      val = wake_i;
      default:                          val = '0;
    endcase
    rdata_o = '0;
    if (rd_i) rdata_o[NUM_EV-1:0] = val;
  end
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
  import irq_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NUM_EV-1:0] raw_set, raw_clr, en_set, en_clr, bits;
  logic              en_load, wake_load;
  logic [NUM_EV-1:0] raw_q, en_q, wake_q, masked, wake_req;

  irq_reg_decode #(.DATA_W(DATA_W), .NUM_EV(NUM_EV)) i_decode (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .raw_set_o   (raw_set),
    .raw_clr_o   (raw_clr),
    .en_set_o    (en_set),
    .en_clr_o    (en_clr),
    .en_load_o   (en_load),
    .wake_load_o (wake_load),
    .bits_o      (bits)
  );

  for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
    irq_event_slice i_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ev_i        (ev_i[k]),
      .raw_set_i   (raw_set[k]),
      .raw_clr_i   (raw_clr[k]),
      .en_set_i    (en_set[k]),
      .en_clr_i    (en_clr[k]),
      .en_load_i   (en_load),
      .wake_load_i (wake_load),
      .bit_i       (bits[k]),
      .raw_o       (raw_q[k]),
      .en_o        (en_q[k]),
      .wake_en_o   (wake_q[k]),
      .masked_o    (masked[k]),
      .wake_req_o  (wake_req[k])
    );
  end

  irq_read_mux #(.DATA_W(DATA_W), .NUM_EV(NUM_EV)) i_rmux (
    .rd_i    (req_i & ~we_i),
    .addr_i  (addr_i),
    .raw_i   (raw_q),
    .en_i    (en_q),
    .wake_i  (wake_q),
    .rdata_o (rdata_o)
  );

  assign irq_o  = |masked;
  assign wake_o = |wake_req;
endmodule

// File: rtl/irq_event_unit_chk.sv
module irq_event_unit_chk
  import irq_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EV = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_EV-1:0] ev_i,
  input logic              req_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic [NUM_EV-1:0] raw_q,
  input logic [NUM_EV-1:0] en_q,
  input logic [NUM_EV-1:0] wake_q
);
  AST_EVENT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((raw_q & $past(ev_i)) == $past(ev_i))); // R2

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ev_i) && req_i && we_i) |=> ((raw_q & $past(ev_i)) == $past(ev_i))); // R10

  AST_RAW_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|ev_i) && !(req_i && we_i)) |=> $stable(raw_q)); // R3

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(raw_q) & ~raw_q)) |-> $past(req_i && we_i)); // R5

  AST_NO_IRQ_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|en_q) |-> !irq_o); // R9

  AST_NO_WAKE_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wake_q) |-> !wake_o); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0)); // R11
endmodule

bind irq_event_unit irq_event_unit_chk #(.DATA_W(DATA_W), .NUM_EV(NUM_EV)) i_chk (.*);

// File: tb/test_irq_event_unit.sv
`timescale 1ns/1ps
module test_irq_event_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ev_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  int m_raw = 0, m_en = 0, m_wake = 0;
  bit finished = 0;

  irq_event_unit i_irq_event_unit (.*);

  always #4 clk_i = ~clk_i;

  // behavioural reference, steps on each clock edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_raw = 0; m_en = 0; m_wake = 0;
    end else begin
      int d, setv, clrv;
      d = int'(wdata_i) & 3;
      setv = int'(ev_i);
      clrv = 0;
      if (req_i && we_i) begin
        case (addr_i)
          4'd0: setv = setv | d;
          4'd1, 4'd4: clrv = d;
          4'd2: m_en = m_en | d;
          4'd3: m_en = m_en & ~d;
          4'd5: m_en = d;
          4'd6: m_wake = d;
          default: ;
        endcase
      end
      m_raw = ((m_raw & ~clrv) | setv) & 3;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0, 4:    return m_raw;
      1:       return m_raw & m_en;
      2, 3, 5: return m_en;
      6:       return m_wake;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the outputs against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R9 irq_o", int'(irq_o), int'((m_raw & m_en) != 0));
      check("R8 wake_o", int'(wake_o), int'((m_raw & m_wake) != 0));
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [1:0] ev);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a[3:0]; wdata_i = d; ev_i = ev;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; ev_i = '0; wdata_i = '0;
  endtask

  task automatic pulse(input logic [1:0] ev);
    @(negedge clk_i);
    ev_i = ev;
    @(negedge clk_i);
    ev_i = '0;
  endtask

  task automatic rd(input string tag, input int a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a[3:0];
    #1;
    check(tag, int'(rdata_o), model_read(a));
    req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 irq_o reset", int'(irq_o), 0);
    check("R1 wake_o reset", int'(wake_o), 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 7; a++) rd("R1 reset read", a);

    pulse(2'b01);
    rd("R2 raw after ovf event", 0);
    rd("R4 masked with enable off", 1);
    wr(2, 32'h1, 2'b00);
    rd("R6 en_set read", 2);
    rd("R4 masked with enable on", 1);
    check("R9 irq high", int'(irq_o), 1);

    wr(0, 32'h0, 2'b00);
    rd("R3 raw write zero", 0);
    wr(0, 32'h2, 2'b00);
    rd("R3 raw debug set", 0);
    wr(1, 32'h2, 2'b00);
    rd("R5 masked clear of disabled delay", 0);
    wr(1, 32'h0, 2'b00);
    rd("R5 masked write zero", 0);

    wr(3, 32'h1, 2'b00);
    rd("R6 en_clr read", 3);
    rd("R6 en_set read after clear", 2);
    check("R9 irq low after disable", int'(irq_o), 0);

    wr(5, 32'h3, 2'b00);
    rd("R7 legacy enable seen at set view", 2);
    rd("R7 legacy enable read", 5);
    rd("R7 legacy status read", 4);
    wr(4, 32'h1, 2'b00);
    rd("R7 legacy status clear seen at raw", 0);

    wr(6, 32'h2, 2'b00);
    rd("R8 wake enable read", 6);
    pulse(2'b10);
    check("R8 wake high", int'(wake_o), 1);
    wr(1, 32'h2, 2'b00);
    check("R8 wake low after clear", int'(wake_o), 0);

    pulse(2'b01);
    wr(1, 32'h3, 2'b01);
    rd("R10 event beats masked clear", 0);
    wr(4, 32'h3, 2'b11);
    rd("R10 both events beat legacy clear", 0);
    wr(1, 32'h3, 2'b00);

    wr(0, 32'hFFFF_FFFC, 2'b00);
    rd("R11 upper data bits ignored", 0);
    wr(4'hA, 32'hFFFF_FFFF, 2'b00);
    rd("R11 unmapped read", 10);
    rd("R11 unmapped write had no effect", 0);
    rd("R11 unmapped write had no effect on enable", 2);
    wr(2, 32'hFFFF_FFFF, 2'b00);
    rd("R11 upper read zero", 2);

    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule